// File: doc/BRIEF.md
# Serial Flash Write Protection Gate

This block sits beside the command decoder of a serial flash with a 4 MB array made of 64 sectors of 64 KB each. It decides, at the end of each chip-select frame, whether a program, a sector erase, a bulk erase or a status-register write may proceed. It also holds the status register that controls protection: a 3-bit block-protect code, a status-lock bit and the write-enable latch. It drives a one-cycle execute pulse or a one-cycle reject pulse for each such command.

The decoder hands over one decoded command per frame on a valid/ready port. A synchronised one-cycle strobe marks each serial clock pulse while chip select is low. At the rising edge of chip select the gate checks four things: the pulse count, the write-enable latch, the protected region for the target address, and the hardware lock. The hardware lock is formed from the write-protect pin and the status-lock bit. Back-pressure rules: `cmd_ready` is high only while `cs_n` is low and no command has been taken in the current frame. A command transfers on a cycle where both `cmd_valid` and `cmd_ready` are high. After that transfer, `cmd_ready` stays low until `cs_n` has been high for a cycle. A command offered while `cmd_ready` is low is not taken.

Top module: `flash_write_gate`

## Requirements
- R1: After reset the status byte reads 00h, no execute or reject pulse is raised, and `cmd_ready` is low while `cs_n` is high.
- R2: `cmd_ready` is high while `cs_n` is low and no command has yet been accepted in the frame. It drops after the first accepted command, and any later command offered in the same frame has no effect.
- R3: The verdict appears in the cycle after the first clock edge that samples `cs_n` high. `go_o` or `reject_o` is then high for exactly one cycle, and `verdict_kind` shows the command kind.
- R4: A write-class command (kind 2, 3, 4 or 5) is executed only when the number of `sck_pulse` strobes counted while `cs_n` was low is a multiple of eight. The count is taken modulo 64. Any other count gives a reject.
- R5: Kind 0 sets the write-enable latch (status bit 1) and kind 1 clears it, whatever the count, with no pulse. A write-class command is rejected when the latch is clear. The latch is cleared by every executed write-class command.
- R6: Let code be the block-protect field (status bits 4:2). Code 0 locks no sector. Codes 1 to 6 lock the top 1, 2, 4, 8, 16 and 32 sectors. Code 7 locks all 64 sectors. The sector is address bits 21:16. Program (kind 3) and sector erase (kind 4) aimed into a locked sector are rejected.
- R7: Bulk erase (kind 5) is rejected whenever the block-protect code is nonzero.
- R8: While status bit 7 (status lock) is 1 and `wp_n` is low, a status write (kind 2) is rejected. When `wp_n` is high, the status write follows the other rules.
- R9: An executed status write loads status bits 4:2 from `cmd_wdata[4:2]` and bit 7 from `cmd_wdata[7]`. Write data bits 0, 1, 5 and 6 are ignored, and status bits 0, 5 and 6 always read 0.
- R10: A rejected command leaves the whole status byte unchanged, including the write-enable latch.
- R11: A frame with no accepted command, or with kind 6 or 7, raises no pulse and changes no status bit.
- R12: `sck_pulse` strobes seen while `cs_n` is high are not counted, and the count restarts at zero for every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Synchronised chip select, active low |
| sck_pulse | input | 1 | One-cycle strobe per serial clock pulse |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | Decoded command offered |
| cmd_ready | output | 1 | Gate can take a command this frame |
| cmd_kind | input | 3 | 0 latch set, 1 latch clear, 2 status write, 3 program, 4 sector erase, 5 bulk erase |
| cmd_addr | input | 22 | Target byte address |
| cmd_wdata | input | 8 | Status write data |
| go_o | output | 1 | One-cycle execute pulse |
| reject_o | output | 1 | One-cycle reject pulse |
| verdict_kind | output | 3 | Kind of the command judged last |
| status_o | output | 8 | Registered status byte |

## Verification
Program commands are aimed at the first locked sector and at the last byte below it, for every protect code. This separates an off-by-one region boundary from a wrong power-of-two size. Pulse counts of 0, 7, 9, 16 and 64 separate a true modulo-eight test from a plain equality with eight or a count that saturates. The status lock is tried with the pin low and high, and the latch with set, clear and absent. This shows that each rejection has its own cause. A second command offered inside one frame, and frames with no command or an unused kind, show that only the first handshake counts and that idle frames leave no trace.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int SR_W        = 8;
  localparam int BP_W        = 3;
  localparam int SR_WEL_BIT  = 1;
  localparam int SR_BP_LSB   = 2;
  localparam int SR_LOCK_BIT = 7;
  localparam int KIND_W      = 3;

  localparam logic [KIND_W-1:0] OP_WEL_SET      = 3'd0;
  localparam logic [KIND_W-1:0] OP_WEL_CLR      = 3'd1;
  localparam logic [KIND_W-1:0] OP_STATUS_WR    = 3'd2;
  localparam logic [KIND_W-1:0] OP_PROGRAM      = 3'd3;
  localparam logic [KIND_W-1:0] OP_SECTOR_ERASE = 3'd4;
  localparam logic [KIND_W-1:0] OP_BULK_ERASE   = 3'd5;

  typedef struct packed {
    logic            lock;
    logic [BP_W-1:0] bp;
    logic            wel;
  } guard_state_t;
endpackage

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter int CNT_W      = 6,
  parameter int CHECK_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck_pulse,
  output logic [CNT_W-1:0] count,
  output logic             aligned
);
  always_ff @(posedge clk) begin
    if (!rst_n)         count <= '0;
    else if (cs_n)      count <= '0;
    else if (sck_pulse) count <= count + 1'b1;
  end

  assign aligned = (count[CHECK_BITS-1:0] == '0);

  // R12
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (count == '0));

  // R12
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sck_pulse) |=> $stable(count));
endmodule

// File: rtl/frame_latch.sv
module frame_latch
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SR_W-1:0]   cmd_wdata,
  output logic              held,
  output logic [KIND_W-1:0] held_kind,
  output logic [ADDR_W-1:0] held_addr,
  output logic [SR_W-1:0]   held_wdata
);
  logic take;

  assign cmd_ready = !cs_n && !held;
  assign take      = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= 1'b0;
      held_kind  <= '0;
      held_addr  <= '0;
      held_wdata <= '0;
    end else if (cs_n) begin
      held <= 1'b0;
    end else if (take) begin
      held       <= 1'b1;
      held_kind  <= cmd_kind;
      held_addr  <= cmd_addr;
      held_wdata <= cmd_wdata;
    end
  end

  // R2
  one_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_n) |=> ($stable(held_kind) && $stable(held_addr)));
endmodule

// File: rtl/zone_guard.sv
module zone_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int SECT_W = 6
) (
  input  logic [BP_W-1:0]   bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_locked,
  output logic              any_locked
);
  localparam int NSEC = 1 << SECT_W;
  localparam logic [SECT_W:0] NSEC_V = (SECT_W+1)'(NSEC);
  localparam logic [SECT_W:0] ONE_V  = (SECT_W+1)'(1);

  logic [SECT_W-1:0] sector;
  logic [SECT_W:0]   span;
  logic [SECT_W:0]   floor_v;

  assign sector = addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    if (bp == '0)  span = '0;
    else if (&bp)  span = NSEC_V;
    else           span = ONE_V << (bp - BP_W'(1));
  end

  assign floor_v     = NSEC_V - span;
  assign addr_locked = (span != '0) && ({1'b0, sector} >= floor_v);
  assign any_locked  = |bp;
endmodule

// File: rtl/flash_write_gate.sv
module flash_write_gate
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int SECT_W     = 6,
  parameter int CNT_W      = 6,
  parameter int CHECK_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_pulse,
  input  logic              wp_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SR_W-1:0]   cmd_wdata,
  output logic              go_o,
  output logic              reject_o,
  output logic [KIND_W-1:0] verdict_kind,
  output logic [SR_W-1:0]   status_o
);
  logic [CNT_W-1:0]  count;
  logic              aligned;
  logic              held;
  logic [KIND_W-1:0] h_kind;
  logic [ADDR_W-1:0] h_addr;
  logic [SR_W-1:0]   h_wdata;
  logic              addr_locked, any_locked;
  logic              cs_q;
  guard_state_t      st;

  pulse_tally #(.CNT_W(CNT_W), .CHECK_BITS(CHECK_BITS)) u_tally (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_pulse(sck_pulse),
    .count(count), .aligned(aligned));

  frame_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .held(held), .held_kind(h_kind),
    .held_addr(h_addr), .held_wdata(h_wdata));

  zone_guard #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_zone (
    .bp(st.bp), .addr(h_addr), .addr_locked(addr_locked),
    .any_locked(any_locked));

  logic frame_end, write_class, hw_lock, target_locked, grant;

  assign frame_end   = cs_n && !cs_q;
  assign hw_lock     = st.lock && !wp_n;
  assign write_class = (h_kind == OP_STATUS_WR) || (h_kind == OP_PROGRAM) ||
                       (h_kind == OP_SECTOR_ERASE) || (h_kind == OP_BULK_ERASE);

  always_comb begin
    unique case (h_kind)
      OP_STATUS_WR:               target_locked = hw_lock;
      OP_PROGRAM, OP_SECTOR_ERASE: target_locked = addr_locked;
      OP_BULK_ERASE:              target_locked = any_locked;
      default:                    target_locked = 1'b0;
    endcase
  end

  assign grant = aligned && st.wel && !target_locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q         <= 1'b1;
      st           <= '0;
      go_o         <= 1'b0;
      reject_o     <= 1'b0;
      verdict_kind <= '0;
    end else begin
      cs_q     <= cs_n;
      go_o     <= 1'b0;
      reject_o <= 1'b0;
      if (frame_end && held) begin
        verdict_kind <= h_kind;
        if (h_kind == OP_WEL_SET) begin
          st.wel <= 1'b1;
        end else if (h_kind == OP_WEL_CLR) begin
          st.wel <= 1'b0;
        end else if (write_class) begin
          if (grant) begin
            go_o   <= 1'b1;
            st.wel <= 1'b0;
            if (h_kind == OP_STATUS_WR) begin
              st.bp   <= h_wdata[SR_BP_LSB +: BP_W];
              st.lock <= h_wdata[SR_LOCK_BIT];
            end
          end else begin
            reject_o <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    status_o                          = '0;
    status_o[SR_WEL_BIT]              = st.wel;
    status_o[SR_BP_LSB +: BP_W]       = st.bp;
    status_o[SR_LOCK_BIT]             = st.lock;
  end

  // R3
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_o && reject_o));

  // R3
  verdict_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o || reject_o) |=> !(go_o || reject_o));

  // R10
  reject_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> $stable(status_o));

  // R4
  count_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> $past(aligned));

  // R8
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && verdict_kind == OP_STATUS_WR) |-> !$past(st.lock && !wp_n));

  // R7
  bulk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && verdict_kind == OP_BULK_ERASE) |-> ($past(st.bp) == '0));

  // R6
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && (verdict_kind == OP_PROGRAM || verdict_kind == OP_SECTOR_ERASE))
      |-> !(&$past(st.bp)));
endmodule

// File: tb/flash_write_gate_bench.sv
module flash_write_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck_pulse = 1'b0;
  logic        wp_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_kind = 3'd0;
  logic [21:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        go_o, reject_o;
  logic [2:0]  verdict_kind;
  logic [7:0]  status_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_sr = 8'h00;

  always #4 clk = ~clk;

  flash_write_gate u_flash_write_gate (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_pulse(sck_pulse), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .go_o(go_o),
    .reject_o(reject_o), .verdict_kind(verdict_kind), .status_o(status_o));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit sector_locked(input logic [21:0] a, input logic [2:0] code);
    if (code == 3'd0) return 1'b0;
    if (code == 3'd7) return 1'b1;
    return int'(a[21:16]) >= (64 - (1 << (code - 1)));
  endfunction

  // one frame: command, npulses strobes, then chip select high; checks verdict
  task automatic issue(input string req, input logic [2:0] kind, input logic [21:0] addr,
                       input logic [7:0] wdata, input int np, input bit with_cmd = 1'b1);
    logic g, r, late;
    logic [7:0] s;
    bit eg, er, ok, locked;
    logic [2:0] bp;
    @(negedge clk);
    cs_n = 1'b0; cmd_valid = with_cmd; cmd_kind = kind; cmd_addr = addr; cmd_wdata = wdata;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < np; i++) begin
      sck_pulse = 1'b1;
      @(negedge clk);
    end
    sck_pulse = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    g = go_o; r = reject_o; s = status_o;
    @(negedge clk);
    late = go_o | reject_o;
    eg = 1'b0; er = 1'b0;
    bp = exp_sr[4:2];
    if (with_cmd) begin
      if (kind == 3'd0) exp_sr[1] = 1'b1;
      else if (kind == 3'd1) exp_sr[1] = 1'b0;
      else if (kind >= 3'd2 && kind <= 3'd5) begin
        case (kind)
          3'd2:    locked = exp_sr[7] && !wp_n;
          3'd5:    locked = (bp != 3'd0);
          default: locked = sector_locked(addr, bp);
        endcase
        ok = ((np % 8) == 0) && exp_sr[1] && !locked;
        if (ok) begin
          eg = 1'b1;
          exp_sr[1] = 1'b0;
          if (kind == 3'd2) begin
            exp_sr[4:2] = wdata[4:2];
            exp_sr[7]   = wdata[7];
          end
        end else er = 1'b1;
      end
    end
    chk(req, "go pulse", g, eg);
    chk(req, "reject pulse", r, er);
    chk(req, "status", s, exp_sr);
    chk("R3", "pulse gone next cycle", late, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "reset status", status_o, 8'h00);
    chk("R1", "reset go", go_o, 1'b0);
    chk("R1", "reset reject", reject_o, 1'b0);
    chk("R1", "ready idle", cmd_ready, 1'b0);
  endtask

  task automatic t_wel;
    issue("R5", 3'd3, 22'h000100, 8'h00, 8);
    issue("R5", 3'd0, 22'h0, 8'h00, 3);
    chk("R5", "latch set", status_o, 8'h02);
    issue("R5", 3'd1, 22'h0, 8'h00, 5);
    chk("R5", "latch clear", status_o, 8'h00);
    issue("R5", 3'd0, 22'h0, 8'h00, 8);
    issue("R5", 3'd4, 22'h010000, 8'h00, 8);
    chk("R5", "latch cleared by write", status_o[1], 1'b0);
  endtask

  task automatic t_count;
    issue("R4", 3'd0, 22'h0, 8'h00, 8);
    issue("R4", 3'd3, 22'h000200, 8'h00, 9);
    issue("R4", 3'd3, 22'h000200, 8'h00, 7);
    issue("R4", 3'd3, 22'h000200, 8'h00, 16);
    issue("R4", 3'd0, 22'h0, 8'h00, 8);
    issue("R4", 3'd3, 22'h000200, 8'h00, 0);
    issue("R4", 3'd0, 22'h0, 8'h00, 8);
    issue("R4", 3'd3, 22'h000200, 8'h00, 64);
  endtask

  task automatic t_status_write;
    issue("R9", 3'd0, 22'h0, 8'h00, 8);
    issue("R9", 3'd2, 22'h0, 8'h6D, 16);
    chk("R9", "status after write", status_o, 8'h0C);
    chk("R3", "verdict kind", verdict_kind, 3'd2);
    issue("R9", 3'd0, 22'h0, 8'h00, 8);
    issue("R9", 3'd2, 22'h0, 8'h00, 16);
  endtask

  task automatic t_zones;
    for (int code = 1; code <= 7; code++) begin
      int lo;
      lo = (code == 7) ? 0 : 64 - (1 << (code - 1));
      issue("R6", 3'd0, 22'h0, 8'h00, 8);
      issue("R6", 3'd2, 22'h0, 8'(code << 2), 16);
      issue("R6", 3'd0, 22'h0, 8'h00, 8);
      issue("R6", 3'd3, {6'(lo), 16'h0000}, 8'h00, 8);
      if (lo > 0) begin
        issue("R6", 3'd0, 22'h0, 8'h00, 8);
        issue("R6", 3'd3, {6'(lo), 16'h0000} - 22'd1, 8'h00, 8);
      end
      issue("R6", 3'd0, 22'h0, 8'h00, 8);
      issue("R6", 3'd4, 22'h3FFFFF, 8'h00, 8);
      issue("R6", 3'd0, 22'h0, 8'h00, 8);
      issue("R6", 3'd3, 22'h000000, 8'h00, 8);
    end
    issue("R6", 3'd0, 22'h0, 8'h00, 8);
    issue("R6", 3'd2, 22'h0, 8'h00, 8);
    chk("R6", "protection cleared", status_o, 8'h00);
  endtask

  task automatic t_bulk;
    issue("R7", 3'd0, 22'h0, 8'h00, 8);
    issue("R7", 3'd2, 22'h0, 8'h04, 8);
    issue("R7", 3'd0, 22'h0, 8'h00, 8);
    issue("R7", 3'd5, 22'h0, 8'h00, 8);
    chk("R10", "status kept on reject", status_o, 8'h06);
    issue("R7", 3'd2, 22'h0, 8'h00, 8);
    issue("R7", 3'd0, 22'h0, 8'h00, 8);
    issue("R7", 3'd5, 22'h0, 8'h00, 8);
  endtask

  task automatic t_hw;
    issue("R8", 3'd0, 22'h0, 8'h00, 8);
    issue("R8", 3'd2, 22'h0, 8'h80, 8);
    wp_n = 1'b0;
    issue("R8", 3'd0, 22'h0, 8'h00, 8);
    issue("R8", 3'd2, 22'h0, 8'h00, 8);
    chk("R10", "lock reject keeps latch", status_o, 8'h82);
    issue("R8", 3'd3, 22'h001000, 8'h00, 8);
    wp_n = 1'b1;
    issue("R8", 3'd0, 22'h0, 8'h00, 8);
    issue("R8", 3'd2, 22'h0, 8'h00, 8);
    chk("R8", "unlocked write", status_o, 8'h00);
  endtask

  task automatic t_idle;
    issue("R5", 3'd0, 22'h0, 8'h00, 8);
    issue("R11", 3'd5, 22'h0, 8'h00, 8, 1'b0);
    issue("R11", 3'd6, 22'h0, 8'hFF, 8);
    issue("R11", 3'd7, 22'h0, 8'hFF, 8);
    chk("R11", "status untouched", status_o, 8'h02);
    issue("R5", 3'd1, 22'h0, 8'h00, 8);
  endtask

  task automatic t_ready;
    @(negedge clk);
    cs_n = 1'b0;
    #1;
    chk("R2", "ready at frame start", cmd_ready, 1'b1);
    cmd_valid = 1'b1; cmd_kind = 3'd0;
    @(negedge clk);
    chk("R2", "ready after accept", cmd_ready, 1'b0);
    cmd_kind = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp_sr[1] = 1'b1;
    chk("R2", "second command ignored", status_o, 8'h02);
    chk("R2", "ready after frame", cmd_ready, 1'b0);
    issue("R2", 3'd1, 22'h0, 8'h00, 8);
  endtask

  task automatic t_stray;
    @(negedge clk);
    sck_pulse = 1'b1;
    repeat (5) @(negedge clk);
    sck_pulse = 1'b0;
    issue("R12", 3'd0, 22'h0, 8'h00, 8);
    issue("R12", 3'd3, 22'h002000, 8'h00, 8);
    issue("R12", 3'd0, 22'h0, 8'h00, 3);
    issue("R12", 3'd3, 22'h002000, 8'h00, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wel();
    t_count();
    t_status_write();
    t_zones();
    t_bulk();
    t_hw();
    t_idle();
    t_ready();
    t_stray();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule